// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

The block connects a single-word host request port to one asynchronous 16-bit EDO DRAM with a million words. It splits the 20-bit word address into a 10-bit row (upper half) and a 10-bit column (lower half). These go out one after the other on a shared address bus. The block drives the row strobe, two byte column strobes, write enable and output enable from registers, so every strobe edge falls on a clock edge. Every analog timing minimum becomes a cycle count parameter, derived from the clock period by the integrator.

The host raises `host_req` with address, data, byte enables and the write flag, and holds them until `host_rdy` pulses. If the host presents the next request on the cycle after that pulse, and it targets the same row, the row stays open and only a new column cycle runs (EDO page mode). A free-running interval counter raises refresh requests. These are served as CAS-before-RAS cycles ahead of any waiting host request, once the open row has been closed.

Top module: `edo_dram_ctrl`

## Requirements
- R1: During and right after reset, `mem_ras_n`, `mem_ucas_n`, `mem_lcas_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` and `host_rdy` are 0.
- R2: When the row strobe falls for an access, `mem_addr` carries `host_addr[19:10]` and has been stable for a cycle. When a column strobe falls, `mem_addr` carries `host_addr[9:0]`.
- R3: `host_be[0]` selects the lower byte (bits 7:0, strobe `mem_lcas_n`) and `host_be[1]` the upper byte (bits 15:8, strobe `mem_ucas_n`). A write changes only the enabled bytes. A read returns 0 in the disabled byte.
- R4: For a write, `mem_we_n` is low for at least one cycle before the column strobe falls, and `mem_dq_oe` is 1 with the write data. For a read, `mem_we_n` stays high and `mem_oe_n` is low when the column strobe falls.
- R5: Counted in cycles: row strobe high at least T_RP, low at least T_RAS, falling edges at least T_RC apart, row-to-column delay at least T_RCD, column strobe low at least T_CAS and high at least T_CP inside a page.
- R6: Read data is captured no earlier than T_RAC cycles after the row strobe falls and T_CAC cycles after the column strobe falls, and it is presented on `host_rdata` while `host_rdy` is high.
- R7: `host_rdy` is a one-cycle pulse, once per request.
- R8: A request for the same row, presented on the cycle after `host_rdy`, reuses the open row without a new row activation.
- R9: A refresh drives both column strobes low before the row strobe falls, with `mem_we_n` and `mem_oe_n` high and `mem_dq_oe` 0.
- R10: Refreshes follow each other at most T_REFI + BURST_LIM + 40 cycles apart, with or without host traffic.
- R11: A due refresh beats new host requests and closes an open page burst.
- R12: The row strobe never stays low more than BURST_LIM + 20 cycles, however long the same-row burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Request, held until `host_rdy` |
| host_addr | input | 20 | Word address: row in [19:10], column in [9:0] |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables: [1] upper, [0] lower |
| host_we | input | 1 | 1 = write, 0 = read |
| host_rdy | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with `host_rdy` |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_ucas_n | output | 1 | Upper byte column strobe, active low |
| mem_lcas_n | output | 1 | Lower byte column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The bench's memory model hands out a poison word whenever read data is sampled before the access times have elapsed. A capture that comes too early therefore shows up as wrong read data, not as a quiet pass. Directed word, lower-byte and upper-byte writes followed by word reads show that the byte strobes are separate. Random traffic spread over a few rows mixes page hits, row changes, reads and writes, and tells the page path apart from the full activation path. A long saturating same-row burst and an idle stretch show the burst cap and the refresh interval under load and without it.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW,
        S_RCD,
        S_CSET,
        S_CLOW,
        S_PAGE,
        S_HIT,
        S_CBR1,
        S_CBR2
    } seq_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/edo_ref_timer.sv
module edo_ref_timer #(
    parameter int T_REFI = 1900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ack,
    output logic ref_pend
);
    localparam int TW = $clog2(T_REFI + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (ref_ack) d.pend = 1'b0;
        if (q.cnt == TW'(T_REFI - 1)) begin
            d.cnt  = '0;
            d.pend = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ref_pend = q.pend;

    // R10: a raised refresh request is only dropped by its acknowledge
    assert_pend_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pend && !ref_ack) |=> q.pend);

endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_ctrl_pkg::*;
#(
    parameter int MA_W      = 10,
    parameter int DATA_W    = 16,
    parameter int T_RP      = 4,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 10,
    parameter int T_RCD     = 2,
    parameter int T_RAH     = 1,
    parameter int T_CAS     = 1,
    parameter int T_CAH     = 1,
    parameter int T_RAC     = 7,
    parameter int T_CAC     = 2,
    parameter int BURST_LIM = 1100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic [2*MA_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [1:0]          host_be,
    input  logic                host_we,
    output logic                host_rdy,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                ref_pend,
    output logic                ref_ack,
    output logic [MA_W-1:0]     mem_addr,
    output logic                mem_ras_n,
    output logic                mem_ucas_n,
    output logic                mem_lcas_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);
    localparam int LANE_W   = DATA_W / 2;
    localparam int T_RP_EFF = imax(T_RP, T_RC - T_RAS);
    localparam int T_CLOW   = imax(T_CAS, T_CAH);
    localparam int CNT_LIM  = BURST_LIM + T_RAS + T_RAC + T_CLOW + T_RP_EFF + 16;
    localparam int CW       = $clog2(CNT_LIM + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [MA_W-1:0]   row;
        logic [MA_W-1:0]   addr;
        logic              ras_n;
        logic              ucas_n;
        logic              lcas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic              rdy;
        logic              ref_ack;
        logic              wr;
        logic [1:0]        be;
        logic [DATA_W-1:0] dq_out;
        logic [DATA_W-1:0] rdata;
        logic [CW-1:0]     ras_cnt;
        logic [CW-1:0]     pre_cnt;
        logic [CW-1:0]     cas_cnt;
    } seq_t;

    seq_t q, d;

    logic [MA_W-1:0]   req_row, req_col;
    logic [1:0]        req_be;
    logic [DATA_W-1:0] lane_mask;
    logic              page_hit;
    logic              ras_ok, pre_ok, read_ok, clow_ok;

    assign req_row = host_addr[2*MA_W-1:MA_W];
    assign req_col = host_addr[MA_W-1:0];
    assign req_be  = (host_be == 2'b00) ? 2'b11 : host_be;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{q.be[g]}};
    end

    assign ras_ok   = (int'(q.ras_cnt) + 1) >= T_RAS;
    assign pre_ok   = (int'(q.pre_cnt) + 1) >= T_RP_EFF;
    assign clow_ok  = (int'(q.cas_cnt) + 1) >= T_CLOW;
    assign read_ok  = ((int'(q.ras_cnt) + 1) >= T_RAC) && ((int'(q.cas_cnt) + 1) >= T_CAC);
    assign page_hit = host_req && (req_row == q.row) && !ref_pend
                      && (int'(q.ras_cnt) < BURST_LIM);

    always_comb begin
        d         = q;
        d.rdy     = 1'b0;
        d.ref_ack = 1'b0;
        d.ras_cnt = q.ras_n ? '0 : ((q.ras_cnt == CW'(CNT_LIM)) ? q.ras_cnt : q.ras_cnt + 1'b1);
        d.pre_cnt = !q.ras_n ? '0 : ((q.pre_cnt == CW'(CNT_LIM)) ? q.pre_cnt : q.pre_cnt + 1'b1);
        d.cas_cnt = (q.ucas_n && q.lcas_n) ? '0
                    : ((q.cas_cnt == CW'(CNT_LIM)) ? q.cas_cnt : q.cas_cnt + 1'b1);
        unique case (q.st)
            S_IDLE: begin
                if (ref_pend) begin
                    d.ucas_n = 1'b0;
                    d.lcas_n = 1'b0;
                    d.we_n   = 1'b1;
                    d.oe_n   = 1'b1;
                    d.st     = S_CBR1;
                end else if (host_req) begin
                    d.addr = req_row;
                    d.row  = req_row;
                    d.st   = S_ROW;
                end
            end
            S_ROW: begin
                if (pre_ok) begin
                    d.ras_n = 1'b0;
                    d.st    = S_RCD;
                end
            end
            S_RCD, S_HIT: begin
                if ((q.st == S_RCD && (int'(q.ras_cnt) + 1) >= T_RAH) ||
                    (q.st == S_HIT && page_hit)) begin
                    d.addr   = req_col;
                    d.we_n   = !host_we;
                    d.oe_n   = host_we;
                    d.dq_out = host_wdata;
                    d.dq_oe  = host_we;
                    d.wr     = host_we;
                    d.be     = req_be;
                    d.st     = S_CSET;
                end else if (q.st == S_HIT && ras_ok) begin
                    d.ras_n = 1'b1;
                    d.st    = S_IDLE;
                end
            end
            S_CSET: begin
                if ((int'(q.ras_cnt) + 1) >= T_RCD) begin
                    d.ucas_n = !q.be[1];
                    d.lcas_n = !q.be[0];
                    d.st     = S_CLOW;
                end
            end
            S_CLOW: begin
                if (clow_ok && (q.wr || read_ok)) begin
                    d.ucas_n = 1'b1;
                    d.lcas_n = 1'b1;
                    d.rdy    = 1'b1;
                    if (!q.wr) d.rdata = mem_dq_in & lane_mask;
                    d.st     = S_PAGE;
                end
            end
            S_PAGE: begin
                d.we_n  = 1'b1;
                d.oe_n  = 1'b1;
                d.dq_oe = 1'b0;
                d.st    = S_HIT;
            end
            S_CBR1: begin
                if (pre_ok) begin
                    d.ras_n = 1'b0;
                    d.st    = S_CBR2;
                end
            end
            S_CBR2: begin
                if (ras_ok) begin
                    d.ras_n   = 1'b1;
                    d.ucas_n  = 1'b1;
                    d.lcas_n  = 1'b1;
                    d.ref_ack = 1'b1;
                    d.st      = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_IDLE;
            q.ras_n   <= 1'b1;
            q.ucas_n  <= 1'b1;
            q.lcas_n  <= 1'b1;
            q.we_n    <= 1'b1;
            q.oe_n    <= 1'b1;
            q.be      <= 2'b11;
            q.pre_cnt <= CW'(CNT_LIM);
        end else begin
            q <= d;
        end
    end

    assign host_rdy   = q.rdy;
    assign host_rdata = q.rdata;
    assign ref_ack    = q.ref_ack;
    assign mem_addr   = q.addr;
    assign mem_ras_n  = q.ras_n;
    assign mem_ucas_n = q.ucas_n;
    assign mem_lcas_n = q.lcas_n;
    assign mem_we_n   = q.we_n;
    assign mem_oe_n   = q.oe_n;
    assign mem_dq_out = q.dq_out;
    assign mem_dq_oe  = q.dq_oe;

    // R7: completion is a single-cycle pulse
    assert_rdy_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdy |=> !q.rdy);

    // R5: the row strobe stays low for the minimum pulse width
    assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ras_n) |-> (int'(q.ras_cnt) >= T_RAS));

    // R2: the row address is already on the bus before the strobe falls
    assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.ras_n) && q.ucas_n && q.lcas_n) |-> $stable(q.addr));

    // R4: write enable leads the column strobe by a cycle
    assert_we_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($fell(q.ucas_n) || $fell(q.lcas_n)) && !q.ras_n && !q.we_n) |-> !$past(q.we_n));

    // R9: refresh leaves write, output enable and data drive idle
    assert_cbr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.ras_n) && !(q.ucas_n && q.lcas_n)) |-> (q.we_n && q.oe_n && !q.dq_oe));

    // R12: the open-row counter never reaches its saturation bound
    assert_burst_cap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ras_n |-> (int'(q.ras_cnt) < CNT_LIM));

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
    parameter int MA_W      = 10,
    parameter int DATA_W    = 16,
    parameter int T_RP      = 4,
    parameter int T_RAS     = 7,
    parameter int T_RC      = 10,
    parameter int T_RCD     = 2,
    parameter int T_RAH     = 1,
    parameter int T_CAS     = 1,
    parameter int T_CAH     = 1,
    parameter int T_RAC     = 7,
    parameter int T_CAC     = 2,
    parameter int T_REFI    = 1900,
    parameter int BURST_LIM = 1100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_req,
    input  logic [2*MA_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [1:0]          host_be,
    input  logic                host_we,
    output logic                host_rdy,
    output logic [DATA_W-1:0]   host_rdata,
    output logic [MA_W-1:0]     mem_addr,
    output logic                mem_ras_n,
    output logic                mem_ucas_n,
    output logic                mem_lcas_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_in
);
    logic ref_pend, ref_ack;

    edo_ref_timer #(.T_REFI(T_REFI)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_ack  (ref_ack),
        .ref_pend (ref_pend)
    );

    edo_seq #(
        .MA_W(MA_W), .DATA_W(DATA_W), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
        .T_RCD(T_RCD), .T_RAH(T_RAH), .T_CAS(T_CAS), .T_CAH(T_CAH),
        .T_RAC(T_RAC), .T_CAC(T_CAC), .BURST_LIM(BURST_LIM)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_be    (host_be),
        .host_we    (host_we),
        .host_rdy   (host_rdy),
        .host_rdata (host_rdata),
        .ref_pend   (ref_pend),
        .ref_ack    (ref_ack),
        .mem_addr   (mem_addr),
        .mem_ras_n  (mem_ras_n),
        .mem_ucas_n (mem_ucas_n),
        .mem_lcas_n (mem_lcas_n),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

endmodule

// File: tb/edo_dram_ctrl_test.sv
`timescale 1ns/1ps
module edo_dram_ctrl_test;
    localparam int REFI  = 600;
    localparam int BLIM  = 150;
    localparam int B_RP  = 4;
    localparam int B_RAS = 7;
    localparam int B_RC  = 10;
    localparam int B_RCD = 2;
    localparam int B_CAS = 1;
    localparam int B_CP  = 1;
    localparam int B_RAC = 7;   // 50 ns at 8 ns per cycle, rounded up
    localparam int B_CAC = 2;   // 12 ns at 8 ns per cycle, rounded up
    localparam int REF_BOUND = REFI + BLIM + 40;
    localparam int RAS_BOUND = BLIM + 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [19:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = 2'b11;
    logic        host_we = 1'b0;
    logic        host_rdy;
    logic [15:0] host_rdata;
    logic [9:0]  mem_addr;
    logic        mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hDEAD;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    edo_dram_ctrl #(.T_REFI(REFI), .BURST_LIM(BLIM)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be), .host_we(host_we),
        .host_rdy(host_rdy), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_ras_n(mem_ras_n), .mem_ucas_n(mem_ucas_n), .mem_lcas_n(mem_lcas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // ---------------- expected memory contents ----------------
    logic [15:0] ref_mem [int unsigned];
    logic [15:0] mdl_mem [int unsigned];

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] ref_rd(input logic [19:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    endfunction

    // ---------------- memory model and timing monitor ----------------
    logic [19:0] cur_addr = '0;
    logic [1:0]  cur_be = 2'b11;
    logic        cur_we = 1'b0;
    int cyc = 0, t_rfall = -1000, t_rrise = -1000, t_cfall = -1000, t_crise = -1000;
    int last_ref = -1, ref_count = 0, act_count = 0;
    bit p_ras = 1, p_ucas = 1, p_lcas = 1, p_we = 1, dvalid = 0;
    logic [9:0] m_row = '0, m_col = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (p_ras && !mem_ras_n) begin
                chk(cyc - t_rrise >= B_RP, "R5 ras precharge", cyc - t_rrise, B_RP);
                chk(cyc - t_rfall >= B_RC, "R5 ras cycle", cyc - t_rfall, B_RC);
                if (!p_ucas || !p_lcas) begin
                    chk(mem_we_n && mem_oe_n && !mem_dq_oe, "R9 cbr controls",
                        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b110);
                    chk(!mem_ucas_n && !mem_lcas_n, "R9 both cas low",
                        {mem_ucas_n, mem_lcas_n}, 2'b00);
                    if (last_ref >= 0)
                        chk(cyc - last_ref <= REF_BOUND, "R10 R11 refresh gap",
                            cyc - last_ref, REF_BOUND);
                    last_ref = cyc;
                    ref_count++;
                end else begin
                    chk(mem_addr == cur_addr[19:10], "R2 row address", mem_addr, cur_addr[19:10]);
                    m_row = mem_addr;
                    act_count++;
                end
                t_rfall = cyc;
            end
            if (!p_ras && mem_ras_n) begin
                chk(cyc - t_rfall >= B_RAS, "R5 ras low min", cyc - t_rfall, B_RAS);
                chk(cyc - t_rfall <= RAS_BOUND, "R12 ras low max", cyc - t_rfall, RAS_BOUND);
                t_rrise = cyc;
            end
            if (!p_ras && !mem_ras_n && p_ucas && p_lcas && !(mem_ucas_n && mem_lcas_n)) begin
                m_col = mem_addr;
                chk(mem_addr == cur_addr[9:0], "R2 column address", mem_addr, cur_addr[9:0]);
                chk({mem_ucas_n, mem_lcas_n} == ~cur_be, "R3 byte strobes",
                    {mem_ucas_n, mem_lcas_n}, ~cur_be);
                chk(cyc - t_rfall >= B_RCD, "R5 ras to cas", cyc - t_rfall, B_RCD);
                if (t_crise > t_rfall)
                    chk(cyc - t_crise >= B_CP, "R5 cas precharge", cyc - t_crise, B_CP);
                if (cur_we) begin
                    chk(!mem_we_n && !p_we && mem_dq_oe, "R4 early write",
                        {mem_we_n, p_we, mem_dq_oe}, 3'b001);
                    begin
                        logic [15:0] old, msk;
                        int unsigned k;
                        k   = {m_row, m_col};
                        old = mdl_mem.exists(k) ? mdl_mem[k] : 16'h0;
                        msk = {{8{!mem_ucas_n}}, {8{!mem_lcas_n}}};
                        mdl_mem[k] = (old & ~msk) | (mem_dq_out & msk);
                    end
                end else begin
                    chk(mem_we_n && !mem_oe_n, "R4 read controls", {mem_we_n, mem_oe_n}, 2'b10);
                end
                t_cfall = cyc;
                dvalid  = 0;
            end
            if (!(p_ucas && p_lcas) && mem_ucas_n && mem_lcas_n && !mem_ras_n)
                chk(cyc - t_cfall >= B_CAS, "R5 cas low min", cyc - t_cfall, B_CAS);
            if (!(p_ucas && p_lcas) && mem_ucas_n && mem_lcas_n) t_crise = cyc;
            // data drive with EDO hold after the column strobe rises
            if (!mem_ras_n && !(mem_ucas_n && mem_lcas_n) && !mem_oe_n && mem_we_n) begin
                if (cyc - t_rfall + 1 >= B_RAC && cyc - t_cfall + 1 >= B_CAC) begin
                    int unsigned k;
                    logic [15:0] w;
                    k = {m_row, m_col};
                    w = mdl_mem.exists(k) ? mdl_mem[k] : 16'h0;
                    mem_dq_in = {mem_ucas_n ? 8'h5A : w[15:8], mem_lcas_n ? 8'hA5 : w[7:0]};
                    dvalid = 1;
                end else begin
                    mem_dq_in = 16'hDEAD;
                    dvalid = 0;
                end
            end else if (!(dvalid && !mem_oe_n)) begin
                mem_dq_in = 16'hDEAD;
                dvalid = 0;
            end
            p_ras  = mem_ras_n;
            p_ucas = mem_ucas_n;
            p_lcas = mem_lcas_n;
            p_we   = mem_we_n;
        end
    end

    // R7: ready is never high two samples in a row
    bit p_rdy = 0;
    always @(negedge clk) begin
        if (rst_n && p_rdy) chk(!host_rdy, "R7 ready pulse", host_rdy, 0);
        p_rdy = host_rdy;
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            chk(0, "watchdog", wd, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- host side ----------------
    task automatic access(input logic [19:0] a, input logic w, input logic [1:0] be,
                          input logic [15:0] wd_in, input bit keep);
        int n = 0;
        host_req   = 1'b1;
        host_addr  = a;
        host_we    = w;
        host_be    = be;
        host_wdata = wd_in;
        cur_addr   = a;
        cur_be     = be;
        cur_we     = w;
        do begin
            @(negedge clk);
            n++;
        end while (!host_rdy && n < 3000);
        chk(n < 3000, "R7 access completes", n, 3000);
        if (w) begin
            ref_mem[int'(a)] = (ref_rd(a) & ~lane_mask(be)) | (wd_in & lane_mask(be));
        end else begin
            chk(host_rdata == (ref_rd(a) & lane_mask(be)), "R3 R6 read data",
                host_rdata, ref_rd(a) & lane_mask(be));
        end
        if (!keep) host_req = 1'b0;
    endtask

    task automatic wait_refresh();
        int r = ref_count;
        int n = 0;
        while (ref_count == r && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (B_RP + 2) @(negedge clk);
    endtask

    initial begin
        int a0, r0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(mem_ras_n && mem_ucas_n && mem_lcas_n && mem_we_n && mem_oe_n && !mem_dq_oe && !host_rdy,
            "R1 reset state", {mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n, mem_oe_n, mem_dq_oe, host_rdy},
            7'b1111100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ras_n && mem_ucas_n && mem_lcas_n && !mem_dq_oe, "R1 after reset",
            {mem_ras_n, mem_ucas_n, mem_lcas_n, mem_dq_oe}, 4'b1110);

        // R3: byte lanes
        access(20'h12345, 1, 2'b11, 16'hA1B2, 0);
        access(20'h12345, 0, 2'b11, 16'h0, 0);
        access(20'h12345, 1, 2'b01, 16'hFFCC, 0);
        access(20'h12345, 0, 2'b11, 16'h0, 0);
        access(20'h12345, 1, 2'b10, 16'h77EE, 0);
        access(20'h12345, 0, 2'b11, 16'h0, 0);
        access(20'h12345, 0, 2'b10, 16'h0, 0);
        access(20'h12345, 0, 2'b01, 16'h0, 0);

        // R8: four same-row back-to-back accesses open the row once
        wait_refresh();
        a0 = act_count;
        access(20'h0C801, 1, 2'b11, 16'h1111, 1);
        access(20'h0C802, 1, 2'b11, 16'h2222, 1);
        access(20'h0C801, 0, 2'b11, 16'h0, 1);
        access(20'h0C802, 0, 2'b11, 16'h0, 0);
        chk(act_count - a0 == 1, "R8 page reuse", act_count - a0, 1);

        // row changes back-to-back each need an activation
        wait_refresh();
        a0 = act_count;
        access(20'h00400, 1, 2'b11, 16'h3333, 1);
        access(20'h00800, 1, 2'b11, 16'h4444, 1);
        access(20'h00400, 0, 2'b11, 16'h0, 0);
        chk(act_count - a0 == 3, "R8 row change activates", act_count - a0, 3);

        // random mix over a few rows
        for (int i = 0; i < 400; i++) begin
            logic [9:0]  rw, cl;
            logic [1:0]  be;
            case ($urandom % 4)
                0: rw = 10'h000;
                1: rw = 10'h001;
                2: rw = 10'h155;
                default: rw = 10'h3FF;
            endcase
            cl = 10'($urandom % 8);
            be = 2'($urandom % 3 + 1);
            access({rw, cl}, 1'($urandom % 2), be, 16'($urandom), 1'($urandom % 4 != 0));
        end
        host_req = 1'b0;

        // R11 R12: saturating same-row burst gets cut and refreshed
        wait_refresh();
        a0 = act_count;
        r0 = ref_count;
        for (int i = 0; i < 120; i++)
            access({10'h2AA, 10'(i % 16)}, 1'(i % 2), 2'b11, 16'(i * 37), 1);
        host_req = 1'b0;
        chk(act_count - a0 >= 3, "R12 burst closed by cap", act_count - a0, 3);
        chk(ref_count - r0 >= 1, "R11 refresh during burst", ref_count - r0, 1);

        // R10: refresh keeps running with an idle host
        r0 = ref_count;
        repeat (3 * REFI) @(negedge clk);
        chk(ref_count - r0 >= 2, "R10 idle refresh", ref_count - r0, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule